// File: doc/BRIEF.md
# Indexed Halfword Extremum Tracker

This block performs one step of a scan for the largest or smallest 16-bit element of a vector, and records where that element was found. Each step consumes two new halfwords packed into a 32-bit word and a 64-bit running state. The state carries the position of the next element, the position of the best element so far and that element's value. The step returns the updated state. A caller feeds the returned state back in with the next pair of elements until the vector is used up. The state register and the memory traversal belong to the caller.

Two mode inputs select the search. One chooses between maximum and minimum. The other chooses whether halfwords are compared as two's-complement or as unsigned numbers. Ties have a fixed rule. Within a pair, the lower halfword wins a tie against the upper one. Against the stored best value, a candidate must be strictly better. As a result, the earliest occurrence of the extremum is kept. A parameter places an optional register on the output. With the default setting the result appears one clock after the inputs.

Top module: `ixt_step_top`

## Requirements
- R1: The state word holds three fields: bits [15:0] are the position of the next element (called `pos`), bits [31:16] are the position of the best element (`best_pos`), and bits [47:32] are the best value (`best_val`). In the pair word, bits [15:0] are the lower candidate and bits [31:16] are the upper candidate.
- R2: The output `pos` equals the input `pos` plus 2, truncated to 16 bits, so 0xFFFF becomes 0x0001.
- R3: Output bits [63:48] are always zero. Input state bits [63:48] have no effect on the output.
- R4: In max mode (`find_min`=0), the lower candidate wins when it is greater than or equal to the upper candidate and strictly greater than `best_val`. The lower candidate then becomes `best_val`, and the input `pos` becomes `best_pos`.
- R5: In max mode, when the lower candidate does not win, the upper candidate wins when it is strictly greater than the lower candidate and strictly greater than `best_val`. The upper candidate then becomes `best_val`, and `best_pos` becomes the input `pos` plus 1, truncated to 16 bits.
- R6: When neither candidate wins, `best_val` and `best_pos` are passed through unchanged.
- R7: In min mode (`find_min`=1), the rules of R4 and R5 apply with less-than-or-equal and strictly-less-than in place of greater-than-or-equal and strictly-greater-than.
- R8: With `signed_cmp`=1, all three values are compared as two's-complement numbers. With `signed_cmp`=0, they are compared as unsigned numbers.
- R9: With the default `OUT_REG`=1, the output shows the result for the inputs present at the previous rising clock edge. While `rst` is high, the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| find_min | input | 1 | 1 selects a minimum search, 0 selects a maximum search |
| signed_cmp | input | 1 | 1 selects two's-complement compare, 0 selects unsigned compare |
| state_in | input | 64 | Running state before this step |
| pair_in | input | 32 | Two new candidates; the lower halfword is the earlier element |
| state_out | output | 64 | Running state after this step |

## Verification
The hardest cases to reach are ties. Random 16-bit values seldom make the two candidates equal, or make a candidate equal to the stored best value, so these cases would rarely come up from random input alone. The stimulus therefore draws each candidate from a small pool that includes copies of the other candidate and of the stored value. It also uses directed steps in which the two candidates are equal, or in which the winning candidate only ties `best_val`. A directed step with the top bit set in a candidate gives opposite winners in signed and unsigned compare. Another directed step starts at position 0xFFFF to check that the positions wrap.

// File: rtl/ixt_pkg.sv
package ixt_pkg;

    // Outcome of one step: which candidate, if any, replaces the stored best
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_LO   = 2'd1,
        WIN_HI   = 2'd2
    } win_e;

    // Search direction
    typedef enum logic {
        DIR_MAX = 1'b0,
        DIR_MIN = 1'b1
    } dir_e;

    // True when a ranks ahead of b in direction dir; or_equal admits ties
    function automatic logic ranks_ahead(input logic signed [16:0] a,
                                         input logic signed [16:0] b,
                                         input dir_e dir,
                                         input logic or_equal);
        logic gt, eq;
        gt = (dir == DIR_MAX) ? (a > b) : (a < b);
        eq = (a == b);
        return gt | (or_equal & eq);
    endfunction

endpackage

// File: rtl/ixt_unpack.sv
module ixt_unpack #(
    parameter int IDX_W   = 16,
    parameter int VAL_W   = 16,
    parameter int STATE_W = 64
) (
    input  logic [STATE_W-1:0] state_in,
    input  logic [2*VAL_W-1:0] pair_in,
    input  logic               signed_cmp,
    output logic [IDX_W-1:0]   pos,
    output logic [IDX_W-1:0]   best_pos,
    output logic [VAL_W-1:0]   best_val,
    output logic [VAL_W-1:0]   cand_lo,
    output logic [VAL_W-1:0]   cand_hi,
    output logic [VAL_W:0]     ext_best,
    output logic [VAL_W:0]     ext_lo,
    output logic [VAL_W:0]     ext_hi
);
    localparam int BEST_POS_LSB = IDX_W;
    localparam int BEST_VAL_LSB = 2 * IDX_W;

    assign pos      = state_in[IDX_W-1:0];
    assign best_pos = state_in[BEST_POS_LSB +: IDX_W];
    assign best_val = state_in[BEST_VAL_LSB +: VAL_W];
    assign cand_lo  = pair_in[VAL_W-1:0];
    assign cand_hi  = pair_in[VAL_W +: VAL_W];

    // One extra bit makes a single signed comparator serve both compare kinds
    assign ext_best = {signed_cmp & best_val[VAL_W-1], best_val};
    assign ext_lo   = {signed_cmp & cand_lo[VAL_W-1],  cand_lo};
    assign ext_hi   = {signed_cmp & cand_hi[VAL_W-1],  cand_hi};
endmodule

// File: rtl/ixt_select.sv
module ixt_select
    import ixt_pkg::*;
#(
    parameter int VAL_W = 16
) (
    input  logic [VAL_W:0] ext_best,
    input  logic [VAL_W:0] ext_lo,
    input  logic [VAL_W:0] ext_hi,
    input  logic           find_min,
    output win_e           win
);
    dir_e dir;
    logic lo_over_hi, lo_over_best, hi_over_lo, hi_over_best;

    assign dir = find_min ? DIR_MIN : DIR_MAX;

    always_comb begin
        lo_over_hi   = ranks_ahead($signed(17'(ext_lo)), $signed(17'(ext_hi)),   dir, 1'b1);
        lo_over_best = ranks_ahead($signed(17'(ext_lo)), $signed(17'(ext_best)), dir, 1'b0);
        hi_over_lo   = ranks_ahead($signed(17'(ext_hi)), $signed(17'(ext_lo)),   dir, 1'b0);
        hi_over_best = ranks_ahead($signed(17'(ext_hi)), $signed(17'(ext_best)), dir, 1'b0);
        if (lo_over_hi && lo_over_best)
            win = WIN_LO;
        else if (hi_over_lo && hi_over_best)
            win = WIN_HI;
        else
            win = WIN_NONE;
    end
endmodule

// File: rtl/ixt_pack.sv
module ixt_pack
    import ixt_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int VAL_W   = 16,
    parameter int STATE_W = 64
) (
    input  win_e               win,
    input  logic [IDX_W-1:0]   pos,
    input  logic [IDX_W-1:0]   best_pos,
    input  logic [VAL_W-1:0]   best_val,
    input  logic [VAL_W-1:0]   cand_lo,
    input  logic [VAL_W-1:0]   cand_hi,
    input  logic [STATE_W-1:0] state_in,
    output logic [STATE_W-1:0] state_next
);
    localparam int USED_W = 2 * IDX_W + VAL_W;
    localparam int PAD_W  = STATE_W - USED_W;

    logic [IDX_W-1:0] new_best_pos;
    logic [VAL_W-1:0] new_best_val;
    logic [PAD_W-1:0] pad;

    always_comb begin
        unique case (win)
            WIN_LO: begin
                new_best_pos = pos;
                new_best_val = cand_lo;
            end
            WIN_HI: begin
                new_best_pos = IDX_W'(pos + IDX_W'(1));
                new_best_val = cand_hi;
            end
            default: begin
                new_best_pos = best_pos;
                new_best_val = best_val;
            end
        endcase
    end

    // Upper bits of the incoming state are discarded
    assign pad = state_in[STATE_W-1:USED_W] & {PAD_W{1'b0}};

    assign state_next = {pad, new_best_val, new_best_pos, IDX_W'(pos + IDX_W'(2))};
endmodule

// File: rtl/ixt_step_top.sv
module ixt_step_top
    import ixt_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int VAL_W   = 16,
    parameter int STATE_W = 64,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 find_min,
    input  logic                 signed_cmp,
    input  logic [STATE_W-1:0]   state_in,
    input  logic [2*VAL_W-1:0]   pair_in,
    output logic [STATE_W-1:0]   state_out
);
    logic [IDX_W-1:0]   pos, best_pos;
    logic [VAL_W-1:0]   best_val, cand_lo, cand_hi;
    logic [VAL_W:0]     ext_best, ext_lo, ext_hi;
    win_e               win;
    logic [STATE_W-1:0] state_next;

    ixt_unpack #(.IDX_W(IDX_W), .VAL_W(VAL_W), .STATE_W(STATE_W)) u_unpack (
        .state_in   (state_in),
        .pair_in    (pair_in),
        .signed_cmp (signed_cmp),
        .pos        (pos),
        .best_pos   (best_pos),
        .best_val   (best_val),
        .cand_lo    (cand_lo),
        .cand_hi    (cand_hi),
        .ext_best   (ext_best),
        .ext_lo     (ext_lo),
        .ext_hi     (ext_hi)
    );

    ixt_select #(.VAL_W(VAL_W)) u_select (
        .ext_best (ext_best),
        .ext_lo   (ext_lo),
        .ext_hi   (ext_hi),
        .find_min (find_min),
        .win      (win)
    );

    ixt_pack #(.IDX_W(IDX_W), .VAL_W(VAL_W), .STATE_W(STATE_W)) u_pack (
        .win        (win),
        .pos        (pos),
        .best_pos   (best_pos),
        .best_val   (best_val),
        .cand_lo    (cand_lo),
        .cand_hi    (cand_hi),
        .state_in   (state_in),
        .state_next (state_next)
    );

    generate
        if (OUT_REG) begin : g_reg
            logic [STATE_W-1:0] state_q;
            always_ff @(posedge clk) begin
                if (rst) state_q <= '0;
                else     state_q <= state_next;
            end
            assign state_out = state_q;
        end else begin : g_comb
            logic unused_clk;
            assign unused_clk = clk ^ rst;
            assign state_out  = state_next;
        end
    endgenerate
endmodule

// File: rtl/ixt_step_chk.sv
module ixt_step_chk #(
    parameter int IDX_W   = 16,
    parameter int VAL_W   = 16,
    parameter int STATE_W = 64,
    parameter bit OUT_REG = 1'b1
) (
    input logic               clk,
    input logic               rst,
    input logic               find_min,
    input logic               signed_cmp,
    input logic [STATE_W-1:0] state_in,
    input logic [2*VAL_W-1:0] pair_in,
    input logic [STATE_W-1:0] state_out
);
    localparam int USED_W = 2 * IDX_W + VAL_W;

    logic [STATE_W-1:0] s_ref;
    logic [2*VAL_W-1:0] p_ref;
    logic               min_ref, sgn_ref, ref_ok;

    generate
        if (OUT_REG) begin : g_lag
            always_ff @(posedge clk) begin
                s_ref   <= state_in;
                p_ref   <= pair_in;
                min_ref <= find_min;
                sgn_ref <= signed_cmp;
                ref_ok  <= !rst;
            end
        end else begin : g_now
            assign s_ref   = state_in;
            assign p_ref   = pair_in;
            assign min_ref = find_min;
            assign sgn_ref = signed_cmp;
            assign ref_ok  = !rst;
        end
    endgenerate

    logic [IDX_W-1:0] r_pos, r_bpos, o_pos, o_bpos;
    logic [VAL_W-1:0] r_bval, r_lo, r_hi, o_bval;
    logic signed [VAL_W:0] xs_old, xs_new;

    assign r_pos  = s_ref[IDX_W-1:0];
    assign r_bpos = s_ref[IDX_W +: IDX_W];
    assign r_bval = s_ref[2*IDX_W +: VAL_W];
    assign r_lo   = p_ref[VAL_W-1:0];
    assign r_hi   = p_ref[VAL_W +: VAL_W];
    assign o_pos  = state_out[IDX_W-1:0];
    assign o_bpos = state_out[IDX_W +: IDX_W];
    assign o_bval = state_out[2*IDX_W +: VAL_W];
    assign xs_old = {sgn_ref & r_bval[VAL_W-1], r_bval};
    assign xs_new = {sgn_ref & o_bval[VAL_W-1], o_bval};

    assert_pos_step_R2: assert property (@(posedge clk) disable iff (rst)
        ref_ok |-> o_pos == IDX_W'(r_pos + IDX_W'(2)));

    assert_pad_zero_R3: assert property (@(posedge clk) disable iff (rst)
        state_out[STATE_W-1:USED_W] == '0);

    // R6: a result pairs with its own position, or the old best passes through
    assert_best_source_R6: assert property (@(posedge clk) disable iff (rst)
        ref_ok |-> ((o_bval == r_bval && o_bpos == r_bpos) ||
                    (o_bval == r_lo && o_bpos == r_pos) ||
                    (o_bval == r_hi && o_bpos == IDX_W'(r_pos + IDX_W'(1)))));

    // R4 / R7: the best value never gets worse in the chosen direction
    assert_no_regress_R7: assert property (@(posedge clk) disable iff (rst)
        ref_ok |-> (min_ref ? (xs_new <= xs_old) : (xs_new >= xs_old)));

    // R5: an upper winner is strictly ahead of the lower candidate
    assert_hi_strict_R5: assert property (@(posedge clk) disable iff (rst)
        (ref_ok && o_bpos == IDX_W'(r_pos + IDX_W'(1)) && o_bpos != r_bpos
         && o_bpos != r_pos) |-> (o_bval == r_hi && r_hi != r_lo));
endmodule

bind ixt_step_top ixt_step_chk #(
    .IDX_W(IDX_W), .VAL_W(VAL_W), .STATE_W(STATE_W), .OUT_REG(OUT_REG)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .find_min   (find_min),
    .signed_cmp (signed_cmp),
    .state_in   (state_in),
    .pair_in    (pair_in),
    .state_out  (state_out)
);

// File: tb/tb_ixt_step_top.sv
module tb_ixt_step_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        find_min = 1'b0;
    logic        signed_cmp = 1'b0;
    logic [63:0] state_in = '0;
    logic [31:0] pair_in = '0;
    logic [63:0] state_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ixt_step_top dut (
        .clk        (clk),
        .rst        (rst),
        .find_min   (find_min),
        .signed_cmp (signed_cmp),
        .state_in   (state_in),
        .pair_in    (pair_in),
        .state_out  (state_out)
    );

    function automatic logic beats(input logic [15:0] a, input logic [15:0] b,
                                   input logic mn, input logic sg, input logic eq);
        int ia, ib;
        ia = sg ? int'($signed(a)) : int'(a);
        ib = sg ? int'($signed(b)) : int'(b);
        if (eq && ia == ib) return 1'b1;
        return mn ? (ia < ib) : (ia > ib);
    endfunction

    function automatic logic [63:0] model(input logic [63:0] s, input logic [31:0] p,
                                          input logic mn, input logic sg);
        logic [15:0] pos, bpos, bval, lo, hi;
        pos = s[15:0]; bpos = s[31:16]; bval = s[47:32];
        lo = p[15:0]; hi = p[31:16];
        if (beats(lo, hi, mn, sg, 1'b1) && beats(lo, bval, mn, sg, 1'b0)) begin
            bval = lo; bpos = pos;
        end else if (beats(hi, lo, mn, sg, 1'b0) && beats(hi, bval, mn, sg, 1'b0)) begin
            bval = hi; bpos = pos + 16'd1;
        end
        return {16'h0, bval, bpos, 16'(pos + 16'd2)};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive at falling edge, result registered at next rising edge, sample at following falling edge
    task automatic step(input string tag, input logic [63:0] s, input logic [31:0] p,
                        input logic mn, input logic sg);
        state_in = s; pair_in = p; find_min = mn; signed_cmp = sg;
        @(negedge clk);
        check(tag, state_out, model(s, p, mn, sg));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        state_in = 64'hFFFF_1234_5678_9ABC;
        pair_in  = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R9 reset", state_out, 64'h0);
        rst = 1'b0;
        @(negedge clk);

        // R9: before the edge the output still holds the previous result
        state_in = 64'h0000_0005_0003_000A; pair_in = 32'h0007_0007;
        #1 check("R9 latency", state_out, model(64'hFFFF_1234_5678_9ABC, 32'hDEAD_BEEF, 1'b0, 1'b0));
        @(negedge clk);

        // R1 / R4: equal candidates, lower wins a tie; best=5 pos=10
        step("R4 tie lo", 64'h0000_0005_0003_000A, 32'h0007_0007, 1'b0, 1'b1);
        check("R1 fields", state_out, 64'h0000_0007_000A_000C);
        // R6: both equal the stored best -> no change
        step("R6 tie best", 64'h0000_0005_0003_000A, 32'h0005_0005, 1'b0, 1'b1);
        check("R6 pass", state_out, 64'h0000_0005_0003_000C);
        // R5: upper wins
        step("R5 hi", 64'h0000_0005_0003_000A, 32'h0009_0003, 1'b0, 1'b1);
        check("R5 pos", state_out, 64'h0000_0009_000B_000C);
        // R2 / R5: position wrap
        step("R5 wrap", 64'h0000_0005_0003_FFFF, 32'h0009_0003, 1'b0, 1'b1);
        check("R2 wrap", state_out, 64'h0000_0009_0000_0001);
        // R3: upper input bits ignored
        step("R3 pad", 64'hABCD_0005_0003_000A, 32'h0001_0002, 1'b0, 1'b0);
        check("R3 zero", state_out, 64'h0000_0005_0003_000C);
        // R8: top bit set flips the outcome between compare kinds
        step("R8 signed", 64'h0000_0001_0002_0004, 32'h0000_8000, 1'b0, 1'b1);
        check("R8 s", state_out, 64'h0000_0001_0002_0006);
        step("R8 unsigned", 64'h0000_0001_0002_0004, 32'h0000_8000, 1'b0, 1'b0);
        check("R8 u", state_out, 64'h0000_8000_0004_0006);
        // R7: min mode tie, lower wins; min with only a tie to best -> pass
        step("R7 min tie", 64'h0000_0005_0003_0010, 32'h0002_0002, 1'b1, 1'b1);
        check("R7 min", state_out, 64'h0000_0002_0010_0012);
        step("R7 min best", 64'h0000_0005_0003_0010, 32'h0005_0008, 1'b1, 1'b0);
        check("R7 min pass", state_out, 64'h0000_0005_0003_0012);

        for (int i = 0; i < 3000; i++) begin
            logic [63:0] s;
            logic [31:0] p;
            logic [15:0] pool [4];
            logic mn, sg;
            s = {$urandom(), $urandom()};
            pool[0] = 16'($urandom());
            pool[1] = s[47:32];
            pool[2] = 16'($urandom() & 32'h8003);
            pool[3] = pool[0];
            p[15:0]  = pool[$urandom_range(0, 3)];
            p[31:16] = pool[$urandom_range(0, 3)];
            mn = 1'($urandom()); sg = 1'($urandom());
            step(mn ? "R7 random" : "R4 random", s, p, mn, sg);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule